// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks up one virtual page in a hashed page table held in memory. A request carries a primary hash, a compare tag, a protection key, the access type and the table base and size mask. The block computes the byte address of the page-table group that the hash selects. It then walks the eight entries of that group in index order over a single-request memory read port. The first entry whose tag matches ends the walk. Only that entry has its second word fetched and its protection evaluated.

A match whose rights deny the access gives a protection fault. That fault is final. The other group is searched only when no entry in the first group matched at all. The other group is selected by the bitwise complement of the hash, and its entries must carry the secondary flag. The result is hit, miss or protection fault, together with the second word of the matching entry. The caller issues one lookup at a time and waits for the done pulse.

Top module: `hpt_group_search`

## Requirements
- R1: After reset, busy, done and mem_req are all 0.
- R2: The group byte offset is (hash << 7) AND the table mask, for a 128-byte group. The address of word 0 of entry i is base + offset + 16*i. Word 1 of the same entry is at that address + 8. Entries are read in order i = 0 to 7.
- R3: An entry matches when all of the following hold in word 0: bit 0 (valid) is 1, bit 1 (secondary flag) equals the current pass (0 for the primary group, 1 for the secondary group), and bits [TAG_W+1:2] equal the requested tag.
- R4: The first matching entry ends the walk. Word 1 is read only for that entry, and no later entry of the group is read.
- R5: Rights come from the key and a 3-bit PP value. With key 0: PP 000, 001 and 010 give read and write; 011, 101 and 110 give read only; 100 and 111 give nothing. With key 1: PP 010 gives read and write; 001, 011 and 110 give read only; 000, 100, 101 and 111 give nothing. The access codes are 00 read, 01 write, and 1x execute. Execute needs read rights.
- R6: Execute is denied when word 1 bit 2 (no-execute) or word 1 bit 3 (guarded) is set.
- R7: The PP value is {word1[DATA_W-1], word1[1:0]}, so the top bit of word 1 is the high PP bit.
- R8: A match that does not grant the access returns result 10 (fault) with rpage equal to word 1 of that entry. The secondary group is then never read. A grant returns result 00 (hit) with rpage equal to word 1.
- R9: The secondary group, at hash' = ~hash, is searched only when none of the eight primary entries matched.
- R10: When neither group matches, the result is 01 (miss) and rpage is 0. This happens after exactly 16 word-0 reads.
- R11: busy rises when a request is accepted and falls in the cycle where done pulses high for exactly one cycle. A start while busy is ignored.
- R12: mem_req is a one-cycle pulse, raised only while busy. The next request is issued only after mem_rvalid has returned the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Lookup request strobe, accepted when not busy |
| req_hash | input | HASH_W | Primary hash |
| req_tag | input | TAG_W | Compare tag (segment ID and abbreviated page index) |
| req_key | input | 1 | Protection key |
| req_acc | input | 2 | Access type: 00 read, 01 write, 1x execute |
| tbl_base | input | ADDR_W | Table base byte address |
| tbl_mask | input | ADDR_W | Table-size mask applied to the group offset |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 2 | 00 hit, 01 miss, 10 protection fault |
| rpage | output | DATA_W | Word 1 of the matching entry, 0 on miss |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
A fixed table population is probed with lookups that each isolate one decision:
- Matches at different slots, to test index order and the number of reads.
- An invalid entry, and an entry with the wrong secondary flag, to test the match rule. Both lead to a secondary hit or to a full miss.
- A denying primary match backed by a granting secondary entry, to show that a fault is final.
- Two matches in one group with different rights, to show that the first match wins.
- Requests with upper hash bits set, to test the mask.
- The PP, key and execute cases, each chosen so that a wrong rights table, a missing no-execute or guarded override, or an ignored high PP bit changes the result.

Directed runs cover a start issued while busy and a reset in the middle of a walk.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
  typedef enum logic [1:0] {
    RES_HIT   = 2'b00,
    RES_MISS  = 2'b01,
    RES_FAULT = 2'b10
  } res_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE0,
    ST_WAIT0,
    ST_ISSUE1,
    ST_WAIT1
  } state_t;

  // word 0 field positions
  localparam int W0_VALID = 0;
  localparam int W0_SEC   = 1;
  localparam int W0_TAG   = 2;
  // word 1 field positions
  localparam int W1_NOEXEC = 2;
  localparam int W1_GUARD  = 3;
endpackage

// File: rtl/hpt_group_addr.sv
`timescale 1ns/1ps
module hpt_group_addr #(
  parameter int ADDR_W     = 32,
  parameter int HASH_W     = 19,
  parameter int IDX_W      = 3,
  parameter int GRP_SHIFT  = 7,
  parameter int ENT_SHIFT  = 4,
  parameter int WORD_BYTES = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [HASH_W-1:0] hash,
  input  logic              sec,
  input  logic [IDX_W-1:0]  idx,
  input  logic              word,
  output logic [ADDR_W-1:0] addr
);
  logic [HASH_W-1:0] hsel;
  logic [ADDR_W-1:0] goff;
  logic [ADDR_W-1:0] eoff;

  always_comb begin
    hsel = sec ? ~hash : hash;
    goff = (ADDR_W'(hsel) << GRP_SHIFT) & mask;
    eoff = ADDR_W'(idx) << ENT_SHIFT;
    addr = base + goff + eoff + (word ? ADDR_W'(WORD_BYTES) : '0);
  end
endmodule

// File: rtl/hpt_entry_match.sv
`timescale 1ns/1ps
module hpt_entry_match
  import hpt_pkg::*;
#(
  parameter int TAG_W = 40
) (
  input  logic [TAG_W+1:0] w0,
  input  logic [TAG_W-1:0] tag,
  input  logic             sec,
  output logic             hit
);
  always_comb
    hit = w0[W0_VALID] && (w0[W0_SEC] == sec) && (w0[W0_TAG +: TAG_W] == tag);
endmodule

// File: rtl/hpt_rights.sv
`timescale 1ns/1ps
module hpt_rights (
  input  logic       pp_hi,
  input  logic       guard,
  input  logic       noexec,
  input  logic [1:0] pp_lo,
  input  logic       key,
  input  logic [1:0] acc,
  output logic       grant
);
  logic [2:0] pp;
  logic       rd_ok;
  logic       wr_ok;
  logic       ex_ok;

  always_comb begin
    pp = {pp_hi, pp_lo};
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    if (!key) begin
      unique case (pp)
        3'b000, 3'b001, 3'b010: begin rd_ok = 1'b1; wr_ok = 1'b1; end
        3'b011, 3'b101, 3'b110: rd_ok = 1'b1;
        default: ;
      endcase
    end else begin
      unique case (pp)
        3'b010:                 begin rd_ok = 1'b1; wr_ok = 1'b1; end
        3'b001, 3'b011, 3'b110: rd_ok = 1'b1;
        default: ;
      endcase
    end
    ex_ok = rd_ok && !(noexec || guard);
    if (acc[1])      grant = ex_ok;
    else if (acc[0]) grant = wr_ok;
    else             grant = rd_ok;
  end
endmodule

// File: rtl/hpt_group_search.sv
`timescale 1ns/1ps
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int HASH_W      = 19,
  parameter int TAG_W       = 40,
  parameter int WAYS        = 8,
  parameter int ENTRY_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [HASH_W-1:0] req_hash,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_key,
  input  logic [1:0]        req_acc,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_mask,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic [DATA_W-1:0] rpage,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W      = $clog2(WAYS);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ENT_SHIFT  = $clog2(ENTRY_BYTES);
  localparam int GRP_SHIFT  = $clog2(WAYS * ENTRY_BYTES);
  localparam int CNT_W      = $clog2(4 * WAYS + 1);

  state_t            state;
  logic [HASH_W-1:0] q_hash;
  logic [TAG_W-1:0]  q_tag;
  logic              q_key;
  logic [1:0]        q_acc;
  logic [ADDR_W-1:0] q_base;
  logic [ADDR_W-1:0] q_mask;
  logic              q_sec;
  logic [IDX_W-1:0]  q_idx;
  logic [ADDR_W-1:0] next_addr;
  logic              w0_hit;
  logic              w1_grant;

  hpt_group_addr #(
    .ADDR_W(ADDR_W), .HASH_W(HASH_W), .IDX_W(IDX_W),
    .GRP_SHIFT(GRP_SHIFT), .ENT_SHIFT(ENT_SHIFT), .WORD_BYTES(WORD_BYTES)
  ) u_addr (
    .base(q_base), .mask(q_mask), .hash(q_hash), .sec(q_sec),
    .idx(q_idx), .word(state == ST_ISSUE1), .addr(next_addr)
  );

  hpt_entry_match #(.TAG_W(TAG_W)) u_match (
    .w0(mem_rdata[TAG_W+1:0]), .tag(q_tag), .sec(q_sec), .hit(w0_hit)
  );

  hpt_rights u_rights (
    .pp_hi(mem_rdata[DATA_W-1]), .guard(mem_rdata[W1_GUARD]),
    .noexec(mem_rdata[W1_NOEXEC]), .pp_lo(mem_rdata[1:0]),
    .key(q_key), .acc(q_acc), .grant(w1_grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= RES_HIT;
      rpage    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      q_hash   <= '0;
      q_tag    <= '0;
      q_key    <= 1'b0;
      q_acc    <= '0;
      q_base   <= '0;
      q_mask   <= '0;
      q_sec    <= 1'b0;
      q_idx    <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            q_hash <= req_hash;
            q_tag  <= req_tag;
            q_key  <= req_key;
            q_acc  <= req_acc;
            q_base <= tbl_base;
            q_mask <= tbl_mask;
            q_sec  <= 1'b0;
            q_idx  <= '0;
            busy   <= 1'b1;
            state  <= ST_ISSUE0;
          end
        end
        ST_ISSUE0, ST_ISSUE1: begin
          mem_req  <= 1'b1;
          mem_addr <= next_addr;
          state    <= (state == ST_ISSUE0) ? ST_WAIT0 : ST_WAIT1;
        end
        ST_WAIT0: begin
          if (mem_rvalid) begin
            if (w0_hit) begin
              state <= ST_ISSUE1;
            end else if (q_idx != IDX_W'(WAYS - 1)) begin
              q_idx <= q_idx + 1'b1;
              state <= ST_ISSUE0;
            end else if (!q_sec) begin
              q_sec <= 1'b1;
              q_idx <= '0;
              state <= ST_ISSUE0;
            end else begin
              result <= RES_MISS;
              rpage  <= '0;
              done   <= 1'b1;
              busy   <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        ST_WAIT1: begin
          if (mem_rvalid) begin
            result <= w1_grant ? RES_HIT : RES_FAULT;
            rpage  <= mem_rdata;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read counter per lookup, used only by the checks below
  logic [CNT_W-1:0] req_cnt;
  always_ff @(posedge clk) begin
    if (rst)                            req_cnt <= '0;
    else if (state == ST_IDLE && start) req_cnt <= '0;
    else if (mem_req)                   req_cnt <= req_cnt + 1'b1;
  end

  p_req_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  p_req_busy_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_free_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_res_code_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'b11));
  p_miss_reads_r10: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_MISS) |-> (req_cnt == CNT_W'(2 * WAYS)));
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_MISS) |-> (rpage == '0));
  p_match_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (done && result != RES_MISS) |-> (req_cnt <= CNT_W'(2 * WAYS + WAYS + 1)));
endmodule

// File: tb/test_hpt_group_search.sv
`timescale 1ns/1ps
module test_hpt_group_search;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int HASH_W = 19;
  localparam int TAG_W  = 40;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] MASK = 32'h0000_3F80;

  typedef struct packed {
    logic [18:0] hash;
    logic [39:0] tag;
    logic        key;
    logic [1:0]  acc;
    logic [1:0]  res;
    logic [7:0]  nreq;
    logic [11:0] w1;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{19'h12305, 40'hA1, 1'b0, 2'd0, 2'b00, 8'd5,  12'd87},
    '{19'h00010, 40'hB2, 1'b0, 2'd1, 2'b10, 8'd2,  12'd257},
    '{19'h7FFA0, 40'hC3, 1'b0, 2'd0, 2'b00, 8'd12, 12'd1525},
    '{19'h00030, 40'hD4, 1'b0, 2'd0, 2'b01, 8'd16, 12'd4095},
    '{19'h40040, 40'hE5, 1'b0, 2'd2, 2'b10, 8'd2,  12'd1025},
    '{19'h00041, 40'hE6, 1'b0, 2'd2, 2'b10, 8'd7,  12'd1051},
    '{19'h00042, 40'hE7, 1'b0, 2'd2, 2'b00, 8'd3,  12'd1059},
    '{19'h00043, 40'hE8, 1'b1, 2'd0, 2'b10, 8'd2,  12'd1073},
    '{19'h00044, 40'hE9, 1'b0, 2'd0, 2'b10, 8'd2,  12'd1089},
    '{19'h00045, 40'hEA, 1'b0, 2'd0, 2'b00, 8'd2,  12'd1105},
    '{19'h00045, 40'hEA, 1'b0, 2'd1, 2'b10, 8'd2,  12'd1105},
    '{19'h00046, 40'hEB, 1'b0, 2'd1, 2'b10, 8'd4,  12'd1125},
    '{19'h00047, 40'hED, 1'b0, 2'd0, 2'b00, 8'd8,  12'd1149},
    '{19'h00048, 40'hEE, 1'b1, 2'd0, 2'b00, 8'd2,  12'd1153}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [HASH_W-1:0] req_hash = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic              req_key = 1'b0;
  logic [1:0]        req_acc = '0;
  logic              busy, done, mem_req;
  logic [1:0]        result;
  logic [DATA_W-1:0] rpage;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int nreq = 0;
  logic [31:0] first_addr = '0;
  logic [31:0] last_addr = '0;
  logic [63:0] mem [2048];

  always #5 clk = ~clk;

  hpt_group_search #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HASH_W(HASH_W), .TAG_W(TAG_W),
    .WAYS(8), .ENTRY_BYTES(16)
  ) i_hpt_group_search (
    .clk(clk), .rst(rst), .start(start), .req_hash(req_hash),
    .req_tag(req_tag), .req_key(req_key), .req_acc(req_acc),
    .tbl_base(BASE), .tbl_mask(MASK), .busy(busy), .done(done),
    .result(result), .rpage(rpage), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk0(input logic [39:0] tag, input logic h, input logic v);
    return (64'(tag) << 2) | (64'(h) << 1) | 64'(v);
  endfunction

  function automatic logic [63:0] mk1(input int loc, input logic hi, input logic g,
                                      input logic n, input logic [1:0] lo);
    return (64'(hi) << 63) | (64'(loc) << 12) | (64'(g) << 3) | (64'(n) << 2) | 64'(lo);
  endfunction

  task automatic put(input int grp, input int idx, input logic [39:0] tag, input logic h,
                     input logic v, input logic hi, input logic g, input logic n,
                     input logic [1:0] lo);
    mem[grp*16 + idx*2]     = mk0(tag, h, v);
    mem[grp*16 + idx*2 + 1] = mk1(grp*16 + idx, hi, g, n, lo);
  endtask

  // memory responder with latency 0..2 extra cycles
  initial begin : responder
    int lat = 0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        nreq++;
        last_addr = mem_addr;
        if (nreq == 1) first_addr = mem_addr;
        repeat (lat) @(negedge clk);
        mem_rdata  = mem[11'((mem_addr - BASE) >> 3)];
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        lat = (lat + 1) % 3;
      end
    end
  end

  // start a lookup and wait for done; returns 1 on timeout
  task automatic run(input vec_t v, input bit ignore_test, output bit tmo);
    @(negedge clk);
    nreq = 0;
    start = 1'b1; req_hash = v.hash; req_tag = v.tag; req_key = v.key; req_acc = v.acc;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", 64'(busy), 64'd1);
    if (ignore_test) begin
      repeat (3) @(negedge clk);
      start = 1'b1; req_hash = 19'h00030; req_tag = 40'hD4; req_acc = 2'd1;
      @(negedge clk);
      start = 1'b0;
    end
    tmo = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      if (done) begin tmo = 1'b0; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_vec(input vec_t v, input int n, input bit ignore_test);
    bit tmo;
    logic [31:0] exp_last;
    run(v, ignore_test, tmo);
    if (tmo) begin
      chk($sformatf("R11 done timeout vec %0d", n), 64'd1, 64'd0);
    end else begin
      case (v.res)
        2'b00:   chk($sformatf("R5 R8 hit result vec %0d", n), 64'(result), 64'(v.res));
        2'b10:   chk($sformatf("R5 R6 R8 fault result vec %0d", n), 64'(result), 64'(v.res));
        default: chk($sformatf("R9 R10 miss result vec %0d", n), 64'(result), 64'(v.res));
      endcase
      chk($sformatf("R4 R9 read count vec %0d", n), 64'(nreq), 64'(v.nreq));
      if (v.w1 == 12'd4095) begin
        chk($sformatf("R10 rpage zero vec %0d", n), rpage, 64'd0);
        exp_last = BASE + 32'(((~v.hash) & 19'h7F)) * 32'd128 + 32'd112;
      end else begin
        chk($sformatf("R7 R8 rpage vec %0d", n), rpage, mem[v.w1]);
        exp_last = BASE + 32'(v.w1) * 32'd8;
      end
      chk($sformatf("R2 first addr vec %0d", n), 64'(first_addr),
          64'(BASE + 32'(v.hash & 19'h7F) * 32'd128));
      chk($sformatf("R2 R3 last addr vec %0d", n), 64'(last_addr), 64'(exp_last));
      @(negedge clk);
      chk($sformatf("R11 done one cycle vec %0d", n), 64'(done), 64'd0);
      chk($sformatf("R11 busy low vec %0d", n), 64'(busy), 64'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit tmo;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    put(8'h05, 1, 40'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h05, 3, 40'hA1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h10, 0, 40'hB2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
    put(8'h6F, 0, 40'hB2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h20, 7, 40'hC3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h5F, 2, 40'hC3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h30, 1, 40'hD4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h4F, 4, 40'hD4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h40, 0, 40'hE5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10);
    put(8'h41, 5, 40'hE6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10);
    put(8'h42, 1, 40'hE7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
    put(8'h43, 0, 40'hE8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    put(8'h44, 0, 40'hE9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
    put(8'h45, 0, 40'hEA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01);
    put(8'h46, 2, 40'hEB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
    put(8'h46, 4, 40'hEB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h47, 0, 40'hEC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h47, 6, 40'hED, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    put(8'h48, 0, 40'hEE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);

    for (int n = 0; n < NV; n++) check_vec(VEC[n], n, 1'b0);

    // R11: a start while busy must not change the running lookup
    check_vec(VEC[0], 100, 1'b1);

    // R1: reset in the middle of a walk
    @(negedge clk);
    nreq = 0;
    start = 1'b1; req_hash = 19'h00030; req_tag = 40'hD4; req_key = 1'b0; req_acc = 2'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after mid reset", 64'(busy), 64'd0);
    chk("R1 mem_req after mid reset", 64'(mem_req), 64'd0);
    chk("R1 done after mid reset", 64'(done), 64'd0);
    repeat (10) @(negedge clk);
    check_vec(VEC[13], 200, 1'b0);
    run(VEC[3], 1'b0, tmo);
    chk("R10 miss after mid reset", 64'(result), 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule